// File: doc/BRIEF.md
# Modem Control and Status Register Block

This block holds the modem-side registers of a 16550-style serial port. It has a five-bit control register, a status register and an eight-bit scratch register. The control register drives four modem output pins: request-to-send, data-terminal-ready and two general-purpose outputs. The status register reports four modem input lines, which are clear-to-send, data-set-ready, ring indicator and carrier detect. Its low half holds change flags that latch transitions on those lines until software reads them.

Setting the loopback bit cuts the block off from the outside. The four output pins go inactive and the external input pins are no longer used. Each control bit then feeds one status line, so driver code can probe for the presence of the port. It can enter loopback with all outputs set, read the status register once to drop stale change flags, then read it again and compare the result. The scratch register only stores a byte. Software uses it to tell port generations apart by writing patterns and reading them back.

Register access goes through a single-cycle read and write port. Read data is combinational from the selected address. A status read clears the change flags at the clock edge that ends the read cycle. External modem inputs pass through a synchronizer of `SYNC_STAGES` flops before they are used.

Top module: `uart_modem_regs`

## Requirements
- R1: After reset the control register, the scratch register, the change flags and all four output pins are zero.
- R2: The control register sits at address 0 and keeps write-data bits 4:0. Bit 0 is DTR, bit 1 is RTS, bit 2 is OUT1, bit 3 is OUT2 and bit 4 is loopback. Reads return those bits with bits 7:5 as zero.
- R3: When loopback is off, each output pin equals its control bit. Writing 0x0F drives all four pins high and leaves loopback off.
- R4: When loopback is on, all output pins are low. The status line bits are then RTS at bit 4 (CTS), DTR at bit 5 (DSR), OUT1 at bit 6 (RI) and OUT2 at bit 7 (DCD). They show one cycle after the control write.
- R5: When loopback is on, changes on the external modem inputs do not alter the status register.
- R6: When loopback is off, status bits 7:4 show the inputs DCD, RI, DSR and CTS (bit 7 down to bit 4). They show SYNC_STAGES+1 clock edges after an input changes.
- R7: Status bits 3:0 are change flags. Bit 0 sets on any change of the CTS line, bit 1 on any change of DSR and bit 3 on any change of DCD. Bit 2 sets only when RI goes from 1 to 0. Each of these applies whether the change comes from the pins or from loopback.
- R8: A status read (address 1) clears the change flags at the end of the read cycle. After 0x1F is written and the status is read once, a second read shows 0x30 in its low six bits.
- R9: If a line change is detected in the same cycle as a status read, its change flag is set after that cycle, not cleared.
- R10: The scratch register at address 2 returns any written byte, such as 0x55 and 0xAA, unchanged.
- R11: Address 3 reads as zero. Writes to address 3 or to the status register change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe for one cycle |
| reg_rd | input | 1 | Read strobe; a status read clears the change flags |
| reg_addr | input | 2 | Register select: 0 control, 1 status, 2 scratch, 3 unused |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected address, combinational |
| cts_in | input | 1 | Clear-to-send input, active high |
| dsr_in | input | 1 | Data-set-ready input, active high |
| ri_in | input | 1 | Ring indicator input, active high |
| dcd_in | input | 1 | Carrier detect input, active high |
| rts_out | output | 1 | Request-to-send output |
| dtr_out | output | 1 | Data-terminal-ready output |
| out1_out | output | 1 | General-purpose output 1 |
| out2_out | output | 1 | General-purpose output 2 |

## Verification
A status read clears the change flags, and a new line transition sets a flag. The two can land on the same clock edge. To force this, the bench writes the control register to enter loopback with RTS set, then issues a status read in the very next cycle. The internal line has already moved, but the flag has not been captured yet. The read in that cycle must still return the old value. The following read must show the CTS change flag set, which shows that the set won over the clear. The cycle-by-cycle reference model also judges every other overlap of reads, writes and input edges.

// File: rtl/uart_mdm_pkg.sv
package uart_mdm_pkg;

    localparam int DATA_W = 8;
    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] ADR_CTL  = 2'd0;
    localparam logic [ADDR_W-1:0] ADR_STAT = 2'd1;
    localparam logic [ADDR_W-1:0] ADR_SCR  = 2'd2;

    // control register, bit 0 first: dtr, rts, out1, out2, loop
    typedef struct packed {
        logic loop;
        logic out2;
        logic out1;
        logic rts;
        logic dtr;
    } mdm_ctl_t;

    localparam int CTL_W = $bits(mdm_ctl_t);

    // modem line vector, placed at status bits 7:4
    typedef struct packed {
        logic dcd;
        logic ri;
        logic dsr;
        logic cts;
    } mdm_line_t;

    localparam int LINE_W = $bits(mdm_line_t);

endpackage

// File: rtl/modem_in_sync.sv
module modem_in_sync #(
    parameter int STAGES = 2,
    parameter int W      = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] pipe_d [STAGES];
    logic [W-1:0] pipe_q [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                assign pipe_d[g] = d;
            end else begin : g_next
                assign pipe_d[g] = pipe_q[g-1];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        for (int i = 0; i < STAGES; i++) begin
            if (!rst_n) pipe_q[i] <= '0;
            else        pipe_q[i] <= pipe_d[i];
        end
    end

    assign q = pipe_q[STAGES-1];

endmodule

// File: rtl/modem_status_track.sv
module modem_status_track
    import uart_mdm_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  mdm_line_t               line_now,
    input  logic                    rd_clr,
    output mdm_line_t               line_q,
    output logic [LINE_W-1:0]       delta_q
);

    typedef struct packed {
        mdm_line_t         line;
        logic [LINE_W-1:0] delta;
    } trk_t;

    trk_t st_d, st_q;
    logic [LINE_W-1:0] hit;

    always_comb begin
        hit[0] = line_now.cts ^ st_q.line.cts;
        hit[1] = line_now.dsr ^ st_q.line.dsr;
        hit[2] = st_q.line.ri & ~line_now.ri;
        hit[3] = line_now.dcd ^ st_q.line.dcd;

        st_d       = st_q;
        st_d.line  = line_now;
        st_d.delta = (rd_clr ? '0 : st_q.delta) | hit;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign line_q  = st_q.line;
    assign delta_q = st_q.delta;

    // R8: a read with no new transition leaves all flags clear
    p_clear_on_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_clr && (line_now == line_q) |=> (delta_q == '0));

    // R7: trailing-edge flag appears only after RI went from 1 to 0
    p_ri_fall_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(delta_q[2]) |-> ($past(line_q.ri) && !line_q.ri));

    // R9: a CTS transition seen during a read still sets its flag
    p_set_beats_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_clr && (line_now.cts != line_q.cts) |=> delta_q[0]);

endmodule

// File: rtl/uart_modem_regs.sv
module uart_modem_regs
    import uart_mdm_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              cts_in,
    input  logic              dsr_in,
    input  logic              ri_in,
    input  logic              dcd_in,
    output logic              rts_out,
    output logic              dtr_out,
    output logic              out1_out,
    output logic              out2_out
);

    typedef struct packed {
        mdm_ctl_t          ctl;
        logic [DATA_W-1:0] scratch;
    } regs_t;

    regs_t regs_d, regs_q;

    mdm_line_t         ext_raw, ext_sync, line_now, line_q;
    logic [LINE_W-1:0] delta_q;
    logic              stat_rd;

    assign ext_raw = '{dcd: dcd_in, ri: ri_in, dsr: dsr_in, cts: cts_in};

    modem_in_sync #(.STAGES(SYNC_STAGES), .W(LINE_W)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (ext_raw),
        .q     (ext_sync)
    );

    always_comb begin
        if (regs_q.ctl.loop) begin
            line_now = '{dcd: regs_q.ctl.out2, ri: regs_q.ctl.out1,
                         dsr: regs_q.ctl.dtr,  cts: regs_q.ctl.rts};
        end else begin
            line_now = ext_sync;
        end
        stat_rd = reg_rd && (reg_addr == ADR_STAT);
    end

    modem_status_track i_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_now (line_now),
        .rd_clr   (stat_rd),
        .line_q   (line_q),
        .delta_q  (delta_q)
    );

    always_comb begin
        regs_d = regs_q;
        if (reg_wr) begin
            case (reg_addr)
                ADR_CTL: regs_d.ctl     = mdm_ctl_t'(reg_wdata[CTL_W-1:0]);
                ADR_SCR: regs_d.scratch = reg_wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    always_comb begin
        case (reg_addr)
            ADR_CTL:  reg_rdata = {{(DATA_W-CTL_W){1'b0}}, regs_q.ctl};
            ADR_STAT: reg_rdata = {line_q, delta_q};
            ADR_SCR:  reg_rdata = regs_q.scratch;
            default:  reg_rdata = '0;
        endcase
    end

    always_comb begin
        rts_out  = regs_q.ctl.rts  & ~regs_q.ctl.loop;
        dtr_out  = regs_q.ctl.dtr  & ~regs_q.ctl.loop;
        out1_out = regs_q.ctl.out1 & ~regs_q.ctl.loop;
        out2_out = regs_q.ctl.out2 & ~regs_q.ctl.loop;
    end

    // R4: no modem output is active while looped back
    p_loop_pins_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        regs_q.ctl.loop |-> !(rts_out || dtr_out || out1_out || out2_out));

    // R4: steady loopback control shows up on the tracked status lines
    p_loop_map_r4: assert property (@(posedge clk) disable iff (!rst_n)
        regs_q.ctl.loop && $stable(regs_q.ctl) |->
        (line_q == {regs_q.ctl.out2, regs_q.ctl.out1, regs_q.ctl.dtr, regs_q.ctl.rts}));

    // R10: a scratch write is held on the next cycle
    p_scratch_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr && (reg_addr == ADR_SCR) |=> (regs_q.scratch == $past(reg_wdata)));

endmodule

// File: tb/test_uart_modem_regs.sv
module test_uart_modem_regs;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       cts_in = 1'b0, dsr_in = 1'b0, ri_in = 1'b0, dcd_in = 1'b0;
    logic       rts_out, dtr_out, out1_out, out2_out;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    uart_modem_regs i_uart_modem_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .cts_in(cts_in), .dsr_in(dsr_in), .ri_in(ri_in), .dcd_in(dcd_in),
        .rts_out(rts_out), .dtr_out(dtr_out), .out1_out(out1_out), .out2_out(out2_out)
    );

    // behavioural reference model
    logic [3:0] m_sync [$];
    logic [4:0] m_ctl;
    logic [7:0] m_scr;
    logic [3:0] m_line, m_flag;

    always @(posedge clk) begin : model
        logic [3:0] ln;
        logic [3:0] nf;
        if (!rst_n) begin
            m_sync = '{4'h0, 4'h0};
            m_ctl = '0; m_scr = '0; m_line = '0; m_flag = '0;
        end else begin
            ln = m_ctl[4] ? {m_ctl[3], m_ctl[2], m_ctl[0], m_ctl[1]} : m_sync[1];
            nf[0] = ln[0] != m_line[0];
            nf[1] = ln[1] != m_line[1];
            nf[2] = m_line[2] && !ln[2];
            nf[3] = ln[3] != m_line[3];
            if (reg_rd && reg_addr == 2'd1) m_flag = '0;
            m_flag = m_flag | nf;
            m_line = ln;
            void'(m_sync.pop_back());
            m_sync.push_front({dcd_in, ri_in, dsr_in, cts_in});
            if (reg_wr && reg_addr == 2'd0) m_ctl = reg_wdata[4:0];
            if (reg_wr && reg_addr == 2'd2) m_scr = reg_wdata;
        end
    end

    function automatic logic [7:0] m_rdata(input logic [1:0] a);
        case (a)
            2'd0:    return {3'b000, m_ctl};
            2'd1:    return {m_line, m_flag};
            2'd2:    return m_scr;
            default: return 8'h00;
        endcase
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%02h expected=%02h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            #2;
            check(m_ctl[4] ? "R4 pins" : "R3 pins",
                  {4'h0, out2_out, out1_out, rts_out, dtr_out},
                  m_ctl[4] ? 8'h00 : {4'h0, m_ctl[3], m_ctl[2], m_ctl[1], m_ctl[0]});
            check(reg_addr == 2'd1 ? "R7 status" : (reg_addr == 2'd2 ? "R10 scratch" : "R2 regread"),
                  reg_rdata, m_rdata(reg_addr));
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [1:0] a, input logic [7:0] exp, input string tag);
        reg_rd = 1'b1; reg_addr = a;
        #1 check(tag, reg_rdata, exp);
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic pins(input logic [3:0] exp, input string tag);
        #1 check(tag, {4'h0, out2_out, out1_out, rts_out, dtr_out}, {4'h0, exp});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle(2);
        // R1 reset state
        rd_reg(2'd0, 8'h00, "R1 control");
        rd_reg(2'd1, 8'h00, "R1 status");
        rd_reg(2'd2, 8'h00, "R1 scratch");
        pins(4'h0, "R1 pins");
        // R3 all outputs on, loop off
        wr_reg(2'd0, 8'h0F);
        pins(4'hF, "R3 0x0F");
        idle(2);
        rd_reg(2'd0, 8'h0F, "R2 readback 0x0F");
        // R2 upper bits dropped
        wr_reg(2'd0, 8'hE3);
        pins(4'h3, "R3 rts dtr only");
        rd_reg(2'd0, 8'h03, "R2 upper bits zero");
        // R6 external inputs, R7 change flags
        wr_reg(2'd0, 8'h00);
        cts_in = 1'b1; dcd_in = 1'b1;
        idle(4);
        rd_reg(2'd1, 8'h99, "R6 cts dcd seen");
        rd_reg(2'd1, 8'h90, "R8 cleared after read");
        ri_in = 1'b1;
        idle(4);
        rd_reg(2'd1, 8'hD0, "R7 no flag on ri rise");
        ri_in = 1'b0;
        idle(4);
        rd_reg(2'd1, 8'h94, "R7 ri fall flag");
        rd_reg(2'd1, 8'h90, "R8 cleared again");
        // R4 loopback
        wr_reg(2'd0, 8'h1F);
        pins(4'h0, "R4 pins idle");
        idle(2);
        rd_reg(2'd1, 8'hF2, "R4 loop map");
        rd_reg(2'd1, 8'hF0, "R8 second read low six 0x30");
        // R5 external pins ignored
        cts_in = 1'b0; dcd_in = 1'b0; dsr_in = 1'b1; ri_in = 1'b1;
        idle(4);
        rd_reg(2'd1, 8'hF0, "R5 inputs ignored");
        // R7 all lines drop in loopback
        wr_reg(2'd0, 8'h10);
        idle(2);
        rd_reg(2'd1, 8'h0F, "R7 loop drop flags");
        rd_reg(2'd1, 8'h00, "R8 clear");
        // R9 read and set in the same cycle
        wr_reg(2'd0, 8'h12);
        rd_reg(2'd1, 8'h00, "R9 read during change");
        rd_reg(2'd1, 8'h11, "R9 flag survived");
        rd_reg(2'd1, 8'h10, "R9 then cleared");
        // R10 scratch
        wr_reg(2'd2, 8'h55);
        rd_reg(2'd2, 8'h55, "R10 0x55");
        wr_reg(2'd2, 8'hAA);
        rd_reg(2'd2, 8'hAA, "R10 0xAA");
        // R11 unused address and status writes
        wr_reg(2'd3, 8'hFF);
        rd_reg(2'd3, 8'h00, "R11 addr3 zero");
        wr_reg(2'd1, 8'hFF);
        idle(2);
        rd_reg(2'd1, 8'h10, "R11 status unchanged");
        rd_reg(2'd0, 8'h12, "R11 control unchanged");
        rd_reg(2'd2, 8'hAA, "R11 scratch unchanged");
        // R6 leave loopback back to synchronized pins
        wr_reg(2'd0, 8'h00);
        pins(4'h0, "R3 all off");
        idle(2);
        rd_reg(2'd1, 8'h63, "R6 back to pins");
        idle(2);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                total++; bad++;
                $display("FAIL watchdog: actual=timeout expected=finish");
            end
        join_any
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule